// File: doc/BRIEF.md
# Bytecode Operand Prefetcher

This block sits between a 16-bit instruction memory port and an interpreter core that consumes a byte-oriented instruction stream. It keeps a small byte queue topped up from memory. The core asks for the next operand and names one of four formats for it. The block then returns the operand already widened to 16 bits and removes the bytes it used. A program-counter load redirects the stream to any byte address, odd addresses included.

The operand side is a valid/ready pair. The core holds `op_valid` and `op_fmt` steady while it waits. `op_ready` rises only once the queue holds enough bytes for that format. `op_data` is valid in any cycle where both are high, and the bytes are consumed at that clock edge. The memory request side is also valid/ready. Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until they are accepted, unless a program-counter load withdraws them. The memory returns exactly one `mem_rsp_valid` beat for each accepted request, in order, and responses cannot be stalled. The format codes are: 0 unsigned byte, 1 signed byte, 2 word, 3 variable-length value.

Top module: `opfetch_top`

## Requirements
- R1: The byte queue holds at most 4 bytes. A memory request is raised only when no request is outstanding and at least two slots are free.
- R2: Format 0 returns the next byte zero-extended to 16 bits and consumes one byte.
- R3: Format 1 returns the next byte sign-extended to 16 bits and consumes one byte.
- R4: Format 2 returns the next two bytes as one 16-bit value, with the first byte in bits 7:0 when FIRST_LOW=1, and consumes two bytes.
- R5: Format 3 with a first byte whose bit 7 is 0 returns that byte (0..127) and consumes one byte.
- R6: Format 3 with bit 7 of the first byte set returns ((first & 0x7F) << 8) | second and consumes two bytes.
- R7: `op_ready` is high only when the queue holds the bytes the selected format needs. Consecutive operands follow the byte stream with no gap and no repeat.
- R8: `pc_load` empties the queue, and `op_ready` is low in the cycle that follows it. The next operand starts at `pc_value`.
- R9: A memory response to a request accepted before a `pc_load` is discarded.
- R10: When `pc_value` is odd, the low byte (even address) of the first returned word is dropped.
- R11: `mem_req_addr` is always even. Under back-pressure, valid and address hold until accepted or until a `pc_load`.
- R12: After reset, `op_ready` is low, the fetch address is 0, and operands begin at byte address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_load | input | 1 | Redirect the stream to `pc_value` |
| pc_value | input | ADDR_W | New byte program counter |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Even byte address of the word requested |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 16 | Read word, even-address byte in bits 7:0 |
| op_valid | input | 1 | Core requests an operand |
| op_fmt | input | 2 | Operand format code |
| op_ready | output | 1 | Operand available |
| op_data | output | 16 | Formatted operand |

## Verification
The checks assume the memory returns only one beat per accepted request, in order. They also assume the core keeps `op_fmt` steady while `op_valid` waits. The bench's memory model accepts at most one request before it answers, with random delay and random request back-pressure. The core-side driver holds the format until the handshake completes. The random mix of formats and redirects includes loads issued while a read is in flight. It also includes loads to odd addresses, so both the discard path and the odd-start path see traffic.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
  typedef enum logic [1:0] {
    FMT_UBYTE = 2'd0,
    FMT_SBYTE = 2'd1,
    FMT_WORD  = 2'd2,
    FMT_VAR   = 2'd3
  } op_fmt_e;

  localparam int unsigned MEM_W   = 16;
  localparam int unsigned BYTE_W  = 8;
endpackage

// File: rtl/opf_byte_queue.sv
module opf_byte_queue #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [1:0]          pop_n,
  input  logic [1:0]          push_n,
  input  logic [7:0]          push_b0,
  input  logic [7:0]          push_b1,
  output logic [DEPTH*8-1:0]  bytes_o,
  output logic [CW-1:0]       count_o
);
  logic [7:0]    slot_q [DEPTH];
  logic [7:0]    slot_d [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;

  always_comb begin
    int base;
    base = int'(count_q) - int'(pop_n);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) slot_d[i] = slot_q[i + int'(pop_n)];
      else                         slot_d[i] = '0;
      if (push_n != 2'd0 && i == base)     slot_d[i] = push_b0;
      if (push_n == 2'd2 && i == base + 1) slot_d[i] = push_b1;
    end
    count_d = CW'(base + int'(push_n));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || flush) slot_q[g] <= '0;
      else                 slot_q[g] <= slot_d[g];
    end
    assign bytes_o[g*8 +: 8] = slot_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) count_q <= '0;
    else                 count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/opf_mem_ctrl.sv
module opf_mem_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_value,
  input  logic [CW-1:0]     count,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  output logic [1:0]        push_n,
  output logic [7:0]        push_b0,
  output logic [7:0]        push_b1
);
  localparam int unsigned ROOM_LIMIT = DEPTH - 2;

  logic [ADDR_W-1:0] fetch_addr_q;
  logic              pend_q;
  logic              drop_q;
  logic              skip_q;
  logic              accept;
  logic              rsp_take;

  assign mem_req_valid = !pend_q && !pc_load && (int'(count) <= int'(ROOM_LIMIT));
  assign mem_req_addr  = fetch_addr_q;
  assign accept        = mem_req_valid && mem_req_ready;
  assign rsp_take      = mem_rsp_valid && pend_q && !drop_q && !pc_load;

  always_comb begin
    push_n  = 2'd0;
    push_b0 = mem_rsp_data[7:0];
    push_b1 = mem_rsp_data[15:8];
    if (rsp_take) begin
      if (skip_q) begin
        push_n  = 2'd1;
        push_b0 = mem_rsp_data[15:8];
      end else begin
        push_n  = 2'd2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_addr_q <= '0;
      pend_q       <= 1'b0;
      drop_q       <= 1'b0;
      skip_q       <= 1'b0;
    end else if (pc_load) begin
      fetch_addr_q <= {pc_value[ADDR_W-1:1], 1'b0};
      skip_q       <= pc_value[0];
      pend_q       <= pend_q && !mem_rsp_valid;
      drop_q       <= pend_q && !mem_rsp_valid;
    end else begin
      if (accept) begin
        pend_q       <= 1'b1;
        fetch_addr_q <= fetch_addr_q + ADDR_W'(2);
      end else if (mem_rsp_valid && pend_q) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
        if (!drop_q) skip_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/opf_formatter.sv
module opf_formatter
  import opfetch_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter bit          FIRST_LOW = 1'b1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [1:0]         fmt,
  input  logic [DEPTH*8-1:0] bytes_i,
  input  logic [CW-1:0]      count,
  input  logic               block,
  output logic               ready,
  output logic [15:0]        data,
  output logic [1:0]         len
);
  logic [7:0] b0;
  logic [7:0] b1;
  logic       have1;
  logic       have2;

  assign b0    = bytes_i[7:0];
  assign b1    = bytes_i[15:8];
  assign have1 = int'(count) >= 1;
  assign have2 = int'(count) >= 2;

  always_comb begin
    ready = 1'b0;
    data  = '0;
    len   = 2'd1;
    unique case (op_fmt_e'(fmt))
      FMT_UBYTE: begin
        ready = have1;
        data  = {8'h00, b0};
      end
      FMT_SBYTE: begin
        ready = have1;
        data  = {{8{b0[7]}}, b0};
      end
      FMT_WORD: begin
        ready = have2;
        len   = 2'd2;
        data  = FIRST_LOW ? {b1, b0} : {b0, b1};
      end
      FMT_VAR: begin
        if (b0[7]) begin
          ready = have2;
          len   = 2'd2;
          data  = {1'b0, b0[6:0], b1};
        end else begin
          ready = have1;
          data  = {8'h00, b0};
        end
      end
      default: ;
    endcase
    if (block) ready = 1'b0;
  end
endmodule

// File: rtl/opfetch_top.sv
module opfetch_top #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEPTH     = 4,
  parameter bit          FIRST_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_value,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  input  logic              op_valid,
  input  logic [1:0]        op_fmt,
  output logic              op_ready,
  output logic [15:0]       op_data
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH*8-1:0] q_bytes;
  logic [CW-1:0]      q_count;
  logic [1:0]         push_n;
  logic [7:0]         push_b0;
  logic [7:0]         push_b1;
  logic [1:0]         fmt_len;
  logic [1:0]         pop_n;
  logic               op_fire;

  assign op_fire = op_valid && op_ready;
  assign pop_n   = op_fire ? fmt_len : 2'd0;

  opf_byte_queue #(.DEPTH(DEPTH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (pc_load),
    .pop_n   (pop_n),
    .push_n  (push_n),
    .push_b0 (push_b0),
    .push_b1 (push_b1),
    .bytes_o (q_bytes),
    .count_o (q_count)
  );

  opf_mem_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_load       (pc_load),
    .pc_value      (pc_value),
    .count         (q_count),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .push_n        (push_n),
    .push_b0       (push_b0),
    .push_b1       (push_b1)
  );

  opf_formatter #(.DEPTH(DEPTH), .FIRST_LOW(FIRST_LOW)) u_fmt (
    .fmt     (op_fmt),
    .bytes_i (q_bytes),
    .count   (q_count),
    .block   (pc_load),
    .ready   (op_ready),
    .data    (op_data),
    .len     (fmt_len)
  );
endmodule

// File: rtl/opfetch_chk.sv
module opfetch_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_load,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              op_valid,
  input logic [1:0]        op_fmt,
  input logic              op_ready,
  input logic [15:0]       op_data,
  input logic [CW-1:0]     count
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= int'(DEPTH));

  assert_room_for_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> int'(count) <= int'(DEPTH) - 2);

  assert_ubyte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_fmt == 2'd0) |-> op_data[15:8] == 8'h00);

  assert_sbyte_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_fmt == 2'd1) |-> (op_data[15:8] == {8{op_data[7]}}));

  assert_var_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_fmt == 2'd3) |-> !op_data[15]);

  assert_flush_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !op_ready);

  assert_even_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_req_addr[0]);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !pc_load) |=>
      (pc_load || (mem_req_valid && $stable(mem_req_addr))));
endmodule

bind opfetch_top opfetch_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_load       (pc_load),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .op_valid      (op_valid),
  .op_fmt        (op_fmt),
  .op_ready      (op_ready),
  .op_data       (op_data),
  .count         (q_count)
);

// File: tb/opfetch_top_tb_top.sv
module opfetch_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_load = 1'b0;
  logic [15:0] pc_value = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_fmt = '0;
  logic        op_ready;
  logic [15:0] op_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] ptr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  opfetch_top dut_i (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .op_valid(op_valid), .op_fmt(op_fmt),
    .op_ready(op_ready), .op_data(op_data)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one outstanding read, random delay and back-pressure
  logic [15:0] rd_addr;
  int          rd_dly;
  bit          rd_busy;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= ($urandom % 4) != 0;
    if (!rst_n) rd_busy <= 0;
    else if (rd_busy) begin
      if (rd_dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {mb(rd_addr + 16'd1), mb(rd_addr)};
        rd_busy       <= 0;
      end else rd_dly <= rd_dly - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      rd_busy <= 1;
      rd_addr <= mem_req_addr;
      rd_dly  <= $urandom % 3;
    end
  end

  task automatic load_pc(input logic [15:0] pc);
    @(negedge clk);
    pc_load = 1'b1; pc_value = pc;
    @(negedge clk);
    pc_load = 1'b0;
    #1 check("R8", {15'd0, op_ready}, 16'd0);
    ptr = pc;
  endtask

  task automatic do_op(input logic [1:0] f, input string tag_in);
    logic [7:0]  b0, b1;
    logic [15:0] exp;
    int          len;
    string       tag;
    int          waited;
    b0 = mb(ptr); b1 = mb(ptr + 16'd1);
    len = 1; tag = tag_in;
    case (f)
      2'd0: begin exp = {8'h00, b0}; if (tag == "") tag = "R2"; end
      2'd1: begin exp = {{8{b0[7]}}, b0}; if (tag == "") tag = "R3"; end
      2'd2: begin exp = {b1, b0}; len = 2; if (tag == "") tag = "R4"; end
      default: begin
        if (b0[7]) begin exp = {1'b0, b0[6:0], b1}; len = 2; if (tag == "") tag = "R6"; end
        else begin exp = {8'h00, b0}; if (tag == "") tag = "R5"; end
      end
    endcase
    @(negedge clk);
    op_valid = 1'b1; op_fmt = f;
    waited = 0;
    #1;
    while (!op_ready && waited < 100) begin
      @(negedge clk); #1; waited++;
    end
    if (!op_ready) check("R7 timeout", 16'd0, 16'd1);
    else check(tag, op_data, exp);
    @(posedge clk);
    #1 op_valid = 1'b0;
    ptr = ptr + 16'(len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R12 ready", {15'd0, op_ready}, 16'd0);
    check("R12 addr", mem_req_addr, 16'd0);
    rst_n = 1'b1;
    ptr = 16'd0;
    do_op(2'd0, "R12");
    do_op(2'd2, "");
    load_pc(16'h0100);
    do_op(2'd0, ""); do_op(2'd1, ""); do_op(2'd2, ""); do_op(2'd3, "");
    load_pc(16'h0205);
    do_op(2'd0, "R10");
    do_op(2'd2, "R10");
    // redirect while a read is outstanding
    @(negedge clk);
    pc_load = 1'b1; pc_value = 16'h0300;
    @(negedge clk);
    pc_load = 1'b0;
    while (!(mem_req_valid && mem_req_ready)) @(negedge clk);
    @(negedge clk);
    pc_load = 1'b1; pc_value = 16'h0481;
    @(negedge clk);
    pc_load = 1'b0;
    ptr = 16'h0481;
    do_op(2'd2, "R9");
    do_op(2'd0, "R9");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 40 == 0) load_pc(16'($urandom));
      do_op(2'($urandom % 4), "");
    end
    for (int i = 0; i < 20; i++) do_op(2'd2, "R7");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule